// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the combinational arithmetic and logic unit of a small 8-bit microcontroller core. In one evaluation it takes two operands, a 5-bit operation code, and the current carry and zero flags. It returns the result byte, a result write enable, and the next values of six status flags: half carry H, sign S, overflow V, negative N, zero Z and carry C. A matching 6-bit flag write mask tells the status register which of those flags to update.

Each operation applies its own flag rules. Add and subtract report carry and half carry as a carry or a borrow. The carry-subtracts chain the zero flag across multi-byte operations. Increment and decrement have their own overflow cases and leave carry alone. The complement operations have their own carry rules. The shifts derive overflow from the bit that moves out. Single-operand operations work on `a_i`. Register file access and instruction decode sit outside the block.

Top module: `alu8_flags`

## Requirements
- R1: Op 0 (add) returns a+b and op 1 (add with carry) returns a+b+c_i, both modulo 256. C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow. All six flags are written (flag_we_o = 6'h3F), and res_we_o is 1.
- R2: Op 2 (subtract) returns a-b modulo 256 with res_we_o = 1 and all six flags written. C is set on a borrow out of bit 7, H on a borrow out of bit 3, and V on signed overflow.
- R3: Op 3 (subtract with carry) and op 5 (compare with carry) compute a-b-c_i with the same borrow flags as R2. For these two ops, Z is 1 only when the result is zero and z_i is 1.
- R4: Op 4 (compare) and op 5 (compare with carry) write all six flags, and res_we_o is 0.
- R5: Whenever S is written, S = N xor V. Whenever N is written, N equals bit 7 of the result.
- R6: Ops 6, 7 and 8 (AND, OR, XOR) return the bitwise result with V = 0. They write S, V, N and Z (flag_we_o = 6'h1E) and do not write H or C.
- R7: Op 9 (increment) returns a+1, and V is 1 only when a = 0x7F. Op 10 (decrement) returns a-1, and V is 1 only when a = 0x80. Both use flag_we_o = 6'h1E.
- R8: Op 11 (one's complement) returns ~a with C = 1 and V = 0. It writes S, V, N, Z and C (flag_we_o = 6'h1F).
- R9: Op 12 (two's complement) returns 0-a and writes all six flags. C = 1 exactly when the result is nonzero, V = 1 only for a = 0x80, and H = 1 when the low nibble of a is nonzero.
- R10: Ops 14 (logical), 15 (rotate through carry) and 16 (arithmetic) shift a right by one. Bit 0 goes to C. The new bit 7 is 0, c_i, or the old bit 7 respectively. N is the new bit 7 and V = N xor C, with flag_we_o = 6'h1F.
- R11: Op 13 (nibble swap) exchanges the two nibbles of a, with res_we_o = 1 and flag_we_o = 0.
- R12: Op codes 17 to 31 give res_o = 0, res_we_o = 0 and flag_we_o = 0.
- R13: A flag_o bit whose flag_we_o bit is 0 reads 0. The flag bit positions are H=5, S=4, V=3, N=2, Z=1, C=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand, and the operand of single-operand ops |
| b_i | input | W | Second operand |
| op_i | input | 5 | Operation code |
| c_i | input | 1 | Current carry flag |
| z_i | input | 1 | Current zero flag |
| res_o | output | W | Result |
| res_we_o | output | 1 | Result is to be written back |
| flag_o | output | 6 | Next flags {H,S,V,N,Z,C} |
| flag_we_o | output | 6 | Per-flag write mask, same bit order |

## Verification
The bench builds the block with its default width W = 8. At that width the 8-bit flag rules apply as specified, and the whole operand space is small enough to cover in one run. Every op code, including the undefined ones, is driven with the corner operands 0x00, 0x7F, 0x80 and 0xFF under all four carry and zero inputs. Seeded random operands then cover the middle of the space. This reaches the overflow edges of increment and decrement, the zero-chaining of the carry-subtracts, and the negation of 0x80.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [4:0]   op_i,
  input  logic         c_i,
  input  logic         z_i,
  output logic [W-1:0] res_o,
  output logic         res_we_o,
  output logic [5:0]   flag_o,
  output logic [5:0]   flag_we_o
);
  localparam int MSB = W - 1;
  localparam int HB  = 3;
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_CP  = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7;
  localparam logic [4:0] OP_XOR = 5'd8,  OP_INC = 5'd9,  OP_DEC = 5'd10, OP_COM = 5'd11;
  localparam logic [4:0] OP_NEG = 5'd12, OP_SWP = 5'd13, OP_LSR = 5'd14, OP_ROR = 5'd15;
  localparam logic [4:0] OP_ASR = 5'd16;

  logic         cin, bin, chain;
  logic [W-1:0] sum, dif;
  logic         h_add, c_add, v_add, h_sub, c_sub, v_sub;

  assign cin   = (op_i == OP_ADC) & c_i;
  assign bin   = ((op_i == OP_SBC) | (op_i == OP_CPC)) & c_i;
  assign chain = (op_i == OP_SBC) | (op_i == OP_CPC);
  assign sum   = a_i + b_i + {{(W-1){1'b0}}, cin};
  assign dif   = a_i - b_i - {{(W-1){1'b0}}, bin};

  assign h_add = (a_i[HB] & b_i[HB]) | (a_i[HB] & ~sum[HB]) | (b_i[HB] & ~sum[HB]);
  assign c_add = (a_i[MSB] & b_i[MSB]) | (a_i[MSB] & ~sum[MSB]) | (b_i[MSB] & ~sum[MSB]);
  assign v_add = (a_i[MSB] == b_i[MSB]) & (sum[MSB] != a_i[MSB]);
  assign h_sub = (dif[HB] & b_i[HB]) | (~a_i[HB] & dif[HB]) | (~a_i[HB] & b_i[HB]);
  assign c_sub = (dif[MSB] & b_i[MSB]) | (~a_i[MSB] & dif[MSB]) | (~a_i[MSB] & b_i[MSB]);
  assign v_sub = (a_i[MSB] != b_i[MSB]) & (dif[MSB] == b_i[MSB]);

  logic [W-1:0] r;
  logic         h, v, c, n, z, s, shift, we;
  logic [5:0]   mask;

  always_comb begin
    r = '0; h = 1'b0; v = 1'b0; c = 1'b0; shift = 1'b0;
    mask = 6'h00; we = 1'b0;
    case (op_i)
      OP_ADD, OP_ADC: begin
        r = sum; h = h_add; v = v_add; c = c_add; mask = 6'h3F; we = 1'b1;
      end
      OP_SUB, OP_SBC: begin
        r = dif; h = h_sub; v = v_sub; c = c_sub; mask = 6'h3F; we = 1'b1;
      end
      OP_CP, OP_CPC: begin
        r = dif; h = h_sub; v = v_sub; c = c_sub; mask = 6'h3F;
      end
      OP_AND: begin r = a_i & b_i; mask = 6'h1E; we = 1'b1; end
      OP_OR:  begin r = a_i | b_i; mask = 6'h1E; we = 1'b1; end
      OP_XOR: begin r = a_i ^ b_i; mask = 6'h1E; we = 1'b1; end
      OP_INC: begin
        r = a_i + 1'b1; v = (a_i == SMAX); mask = 6'h1E; we = 1'b1;
      end
      OP_DEC: begin
        r = a_i - 1'b1; v = (a_i == SMIN); mask = 6'h1E; we = 1'b1;
      end
      OP_COM: begin
        r = ~a_i; c = 1'b1; mask = 6'h1F; we = 1'b1;
      end
      OP_NEG: begin
        r = '0 - a_i;
        h = r[HB] | a_i[HB];
        v = (a_i == SMIN);
        c = (r != '0);
        mask = 6'h3F; we = 1'b1;
      end
      OP_SWP: begin
        r = {a_i[W/2-1:0], a_i[W-1:W/2]}; we = 1'b1;
      end
      OP_LSR: begin
        r = {1'b0, a_i[MSB:1]}; c = a_i[0]; shift = 1'b1; mask = 6'h1F; we = 1'b1;
      end
      OP_ROR: begin
        r = {c_i, a_i[MSB:1]}; c = a_i[0]; shift = 1'b1; mask = 6'h1F; we = 1'b1;
      end
      OP_ASR: begin
        r = {a_i[MSB], a_i[MSB:1]}; c = a_i[0]; shift = 1'b1; mask = 6'h1F; we = 1'b1;
      end
      default: begin
        r = '0; mask = 6'h00; we = 1'b0;
      end
    endcase
    n = r[MSB];
    if (shift) v = n ^ c;
    s = n ^ v;
    z = (r == '0) & (~chain | z_i);
  end

  logic [5:0] all_flags;
  always_comb begin
    all_flags     = '0;
    all_flags[FH] = h;
    all_flags[FS] = s;
    all_flags[FV] = v;
    all_flags[FN] = n;
    all_flags[FZ] = z;
    all_flags[FC] = c;
  end

  assign res_o     = r;
  assign res_we_o  = we;
  assign flag_o    = all_flags & mask;
  assign flag_we_o = mask;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [4:0]   op_i,
  input logic         c_i,
  input logic         z_i,
  input logic [W-1:0] res_o,
  input logic         res_we_o,
  input logic [5:0]   flag_o,
  input logic [5:0]   flag_we_o
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (flag_we_o[4])
      assert_sign_rule_R5: assert (flag_o[4] == (flag_o[3] ^ flag_o[2]));
    if (flag_we_o[2])
      assert_neg_bit_R5: assert (flag_o[2] == res_o[W-1]);
    assert_masked_zero_R13: assert ((flag_o & ~flag_we_o) == 6'h00);
    if (op_i == 5'd4 || op_i == 5'd5)
      assert_cmp_nowrite_R4: assert (!res_we_o && flag_we_o == 6'h3F);
    if ((op_i == 5'd3 || op_i == 5'd5) && !z_i)
      assert_zero_chain_R3: assert (!flag_o[1]);
    if (op_i == 5'd11)
      assert_com_flags_R8: assert (flag_o[0] && !flag_o[3]);
    if (op_i == 5'd9 && a_i != SMAX)
      assert_inc_ovf_R7: assert (!flag_o[3]);
    if (op_i == 5'd13)
      assert_swap_R11: assert (res_o[W/2-1:0] == a_i[W-1:W/2] && flag_we_o == 6'h00);
    if (op_i > 5'd16)
      assert_undef_R12: assert (!res_we_o && flag_we_o == 6'h00 && res_o == '0);
    if (op_i >= 5'd14 && op_i <= 5'd16)
      assert_shift_carry_R10: assert (flag_o[0] == a_i[0]);
  end
  logic unused_ok;
  assign unused_ok = &{1'b0, b_i, c_i};
endmodule

bind alu8_flags alu8_flags_chk #(.W(W)) chk (
  .a_i(a_i), .b_i(b_i), .op_i(op_i), .c_i(c_i), .z_i(z_i),
  .res_o(res_o), .res_we_o(res_we_o), .flag_o(flag_o), .flag_we_o(flag_we_o)
);

// File: tb/tb_alu8_flags.sv
module tb_alu8_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a, b;
  logic [4:0] op;
  logic       cf, zf;
  logic [7:0] res;
  logic       res_we;
  logic [5:0] flg, flg_we;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  alu8_flags #(.W(8)) dut (
    .a_i(a), .b_i(b), .op_i(op), .c_i(cf), .z_i(zf),
    .res_o(res), .res_we_o(res_we), .flag_o(flg), .flag_we_o(flg_we)
  );

  function automatic logic [20:0] model(input logic [4:0] o, input logic [7:0] x,
                                        input logic [7:0] y, input logic ci, input logic zi);
    int xi = x, yi = y, sx, sy, t, sv, k;
    int rr = 0;
    logic h = 0, v = 0, c = 0, n, s, z, we = 1, chainz = 0, hb;
    logic [5:0] m = 6'h3F;
    sx = (xi > 127) ? xi - 256 : xi;
    sy = (yi > 127) ? yi - 256 : yi;
    case (o)
      0, 1: begin
        k = (o == 1) ? int'(ci) : 0;
        t = xi + yi + k; rr = t % 256; c = (t > 255);
        h = ((xi % 16) + (yi % 16) + k) > 15;
        sv = sx + sy + k; v = (sv > 127) || (sv < -128);
      end
      2, 3, 4, 5: begin
        k = (o == 3 || o == 5) ? int'(ci) : 0;
        t = xi - yi - k; rr = (t + 512) % 256; c = (t < 0);
        h = ((xi % 16) - (yi % 16) - k) < 0;
        sv = sx - sy - k; v = (sv > 127) || (sv < -128);
        chainz = (o == 3 || o == 5);
        we = !(o == 4 || o == 5);
      end
      6: begin rr = xi & yi; m = 6'h1E; end
      7: begin rr = xi | yi; m = 6'h1E; end
      8: begin rr = xi ^ yi; m = 6'h1E; end
      9: begin rr = (xi + 1) % 256; v = (xi == 127); m = 6'h1E; end
      10: begin rr = (xi + 255) % 256; v = (xi == 128); m = 6'h1E; end
      11: begin rr = 255 - xi; c = 1; v = 0; m = 6'h1F; end
      12: begin
        rr = (256 - xi) % 256; c = (xi != 0); v = (xi == 128); h = (xi % 16) != 0;
      end
      13: begin rr = (xi % 16) * 16 + xi / 16; m = 6'h00; end
      14, 15, 16: begin
        hb = (o == 14) ? 1'b0 : (o == 15) ? ci : x[7];
        rr = xi / 2 + (hb ? 128 : 0); c = x[0]; m = 6'h1F;
      end
      default: begin rr = 0; we = 0; m = 6'h00; end
    endcase
    n = (rr >= 128);
    if (o >= 14 && o <= 16) v = n ^ c;
    s = n ^ v;
    z = (rr == 0) && (!chainz || zi);
    return {rr[7:0], we, ({h, s, v, n, z, c} & m), m};
  endfunction

  function automatic string tag(input logic [4:0] o);
    case (o)
      0, 1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R3 R4";
      6, 7, 8: return "R6";
      9, 10: return "R7";
      11: return "R8";
      12: return "R9";
      13: return "R11";
      14, 15, 16: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y,
                       input logic ci, input logic zi);
    logic [20:0] e;
    @(negedge clk);
    op = o; a = x; b = y; cf = ci; zf = zi;
    #2;
    e = model(o, x, y, ci, zi);
    checks++;
    if ({res, res_we, flg, flg_we} !== e) begin
      fails++;
      $display("FAIL %s op=%0d a=%02h b=%02h c=%0b z=%0b got res=%02h we=%0b f=%02h m=%02h exp res=%02h we=%0b f=%02h m=%02h",
               tag(o), o, x, y, ci, zi, res, res_we, flg, flg_we,
               e[20:13], e[12], e[11:6], e[5:0]);
    end
    checks++;
    if (flg_we[4] && (flg[4] !== (flg[3] ^ flg[2]))) begin
      fails++;
      $display("FAIL R5 op=%0d got S=%0b exp S=%0b", o, flg[4], flg[3] ^ flg[2]);
    end
    checks++;
    if ((flg & ~flg_we) !== 6'h00) begin
      fails++;
      $display("FAIL R13 op=%0d got %02h exp 00", o, flg & ~flg_we);
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] corner [4];
    corner[0] = 8'h00; corner[1] = 8'h7F; corner[2] = 8'h80; corner[3] = 8'hFF;
    op = 5'd0; a = 8'h00; b = 8'h00; cf = 1'b0; zf = 1'b0;
    #5;
    checks++;
    if ({res, res_we, flg, flg_we} !== {8'h00, 1'b1, 6'b000010, 6'h3F}) begin
      fails++;
      $display("FAIL R1 reset-time add got %02h %0b %02h %02h exp 00 1 02 3f", res, res_we, flg, flg_we);
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    for (int o = 0; o < 32; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int f = 0; f < 4; f++)
            apply(o[4:0], corner[i], corner[j], f[0], f[1]);
    apply(5'd9, 8'h7F, 8'h00, 1'b0, 1'b0);
    apply(5'd10, 8'h80, 8'h00, 1'b1, 1'b1);
    apply(5'd12, 8'h80, 8'h00, 1'b0, 1'b0);
    apply(5'd12, 8'h00, 8'h00, 1'b1, 1'b0);
    apply(5'd5, 8'h42, 8'h41, 1'b1, 1'b1);
    apply(5'd5, 8'h42, 8'h41, 1'b1, 1'b0);
    apply(5'd1, 8'h0F, 8'h00, 1'b1, 1'b0);
    apply(5'd15, 8'h01, 8'h00, 1'b1, 1'b0);
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++)
      apply(5'($urandom % 18), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule